// File: doc/BRIEF.md
# Variable-Page-Size Associative TLB

This block is a small fully associative address translation cache. Each slot holds its own page size (4 KiB, 64 KiB, 1 MiB or 16 MiB), a virtual page number, a physical frame number, an address-space tag, a global flag and a bundle of memory attributes. A lookup compares the incoming virtual address against every slot at once. A slot hits when it is valid, the address falls inside the range that slot covers, and either the slot is global or its tag equals the context tag sent with the request. On a hit the block returns the translated address and the slot's attributes.

Lookups form a stream. A request is taken when `req_valid` and `req_ready` are both high on a rising edge. The result is registered and appears on the next cycle with `rsp_valid` high. It stays unchanged until `rsp_ready` takes it. While a result is held and `rsp_ready` is low, `req_ready` is low, so back-pressure reaches the requester without any loss. Fill, invalidate-all and invalidate-by-tag are plain single-cycle pulses. A fill goes either to a round-robin slot or to an explicit index.

Top module: `vtlb_top`

## Requirements
- R1: After reset no slot is valid, `rsp_valid` is 0, `req_ready` is 1, every lookup misses, and the round-robin pointer is 0.
- R2: Let N = 12 + 4*size_code, where size_code 0,1,2,3 selects 4 KiB, 64 KiB, 1 MiB or 16 MiB. Let base = vpn << N and mask = 2^N - 1. A valid slot covers the address range from base to base + mask, both ends included. An address outside that range never hits the slot.
- R3: A non-global slot hits only when its stored tag equals `ctx_asid`. A global slot ignores the tag.
- R4: On a hit, `rsp_pa` = (pfn << N) | (va & mask) of the winning slot, and the attribute outputs carry that slot's fields. On a miss, `rsp_hit`, `rsp_pa` and all attribute outputs are 0.
- R5: The attributes are as follows. `mtype` is 2 bits: 0 strongly ordered, 1 device, 2 normal. `ap` is 3 bits. The domain field is 4 bits, and its access kinds are numbered 0 none, 1 client, 2 reserved, 3 manager. There is also one bit each for non-cacheable, section descriptor and execute-never. In the bench each attribute set is packed as {mtype, nc, sect, xn, ap, dom}.
- R6: When several slots hit, the one with the lowest index supplies the result, and `rsp_multi` is 1 in that result only.
- R7: An accepted request gives `rsp_valid` on the next cycle. `req_ready` is 1 exactly when no result is held or `rsp_ready` is 1. A held result keeps its values until it is accepted.
- R8: If `fill_use_idx` is 1, a fill writes slot `fill_idx` and leaves the round-robin pointer as it is. Otherwise the fill writes the slot the pointer names, and the pointer advances, wrapping from the last slot to 0.
- R9: A fill with `fill_basic` = 1 ignores the size, global and attribute inputs. It stores a 4 KiB, non-global slot with mtype normal, nc 0, sect 0, xn 0, ap 0 and domain 1 (client).
- R10: `inv_asid_en` clears every non-global slot whose tag equals `inv_asid`. Global slots and slots with other tags stay valid.
- R11: `inv_all` clears every slot.
- R12: A fill in the same cycle as either invalidate is dropped, and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_va | input | 32 | Virtual address to translate |
| ctx_asid | input | 8 | Current context tag for the request |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | A slot matched |
| rsp_multi | output | 1 | More than one slot matched |
| rsp_pa | output | 32 | Translated address |
| rsp_mtype | output | 2 | Memory type |
| rsp_nc | output | 1 | Non-cacheable |
| rsp_sect | output | 1 | Section descriptor |
| rsp_xn | output | 1 | Execute-never |
| rsp_ap | output | 3 | Access permissions |
| rsp_dom | output | 4 | Domain |
| fill_en | input | 1 | Write one slot |
| fill_use_idx | input | 1 | Use fill_idx instead of the pointer |
| fill_idx | input | 4 | Explicit slot index |
| fill_basic | input | 1 | Store default small-page attributes |
| fill_vpn | input | 20 | Virtual page number |
| fill_pfn | input | 20 | Physical frame number |
| fill_size | input | 2 | Page size code |
| fill_asid | input | 8 | Address-space tag |
| fill_global | input | 1 | Slot ignores tag |
| fill_mtype | input | 2 | Memory type |
| fill_nc | input | 1 | Non-cacheable |
| fill_sect | input | 1 | Section descriptor |
| fill_xn | input | 1 | Execute-never |
| fill_ap | input | 3 | Access permissions |
| fill_dom | input | 4 | Domain |
| inv_all | input | 1 | Clear all slots |
| inv_asid_en | input | 1 | Clear non-global slots with a given tag |
| inv_asid | input | 8 | Tag to clear |

## Verification
The hardest case to reach is several slots hitting one address. No normal fill sequence creates it, because only overlapping fills produce it. The bench first places a small page through the round-robin path. It then writes the same page with a different frame into a high explicit index. Next it moves slot 0 away with an explicit overwrite, so the lowest-index winner changes, and lookups confirm that the lowest slot wins. A held result under back-pressure is also hard to reach. The bench holds `rsp_ready` low while a second request waits, and it checks that the held result is stable and that both results come out in order once `rsp_ready` is released.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

  localparam int unsigned PG_BASE_SHIFT = 12;
  localparam int unsigned PG_MAX_SHIFT  = 24;

  typedef enum logic [1:0] {
    MT_STRONG = 2'd0,
    MT_DEVICE = 2'd1,
    MT_NORMAL = 2'd2
  } mem_kind_e;

  typedef enum logic [1:0] {
    DA_NONE   = 2'd0,
    DA_CLIENT = 2'd1,
    DA_RSVD   = 2'd2,
    DA_MGR    = 2'd3
  } dom_access_e;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_64K  = 2'd1,
    PG_1M   = 2'd2,
    PG_16M  = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic [1:0] mtype;
    logic       nc;
    logic       sect;
    logic       xn;
    logic [2:0] ap;
    logic [3:0] dom;
  } attr_t;

  function automatic logic [4:0] page_shift(input logic [1:0] code);
    return 5'(PG_BASE_SHIFT) + {1'b0, code, 2'b00};
  endfunction

  function automatic attr_t basic_attr();
    attr_t a;
    a.mtype = MT_NORMAL;
    a.nc    = 1'b0;
    a.sect  = 1'b0;
    a.xn    = 1'b0;
    a.ap    = 3'd0;
    a.dom   = {2'b00, DA_CLIENT};
    return a;
  endfunction

endpackage

// File: rtl/vtlb_store.sv
module vtlb_store
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic               fill_use_idx,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic               fill_basic,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic [1:0]         fill_size,
  input  logic [ASID_W-1:0]  fill_asid,
  input  logic               fill_global,
  input  attr_t              fill_attr,
  input  logic               inv_all,
  input  logic               inv_asid_en,
  input  logic [ASID_W-1:0]  inv_asid,
  output logic [ENTRIES-1:0] ent_valid,
  output logic [VPN_W-1:0]   ent_vpn    [ENTRIES],
  output logic [PFN_W-1:0]   ent_pfn    [ENTRIES],
  output logic [1:0]         ent_size   [ENTRIES],
  output logic [ASID_W-1:0]  ent_asid   [ENTRIES],
  output logic               ent_global [ENTRIES],
  output attr_t              ent_attr   [ENTRIES],
  output logic [IDX_W-1:0]   rr_ptr
);

  logic             fill_go;
  logic [IDX_W-1:0] tgt;
  logic [1:0]       eff_size;
  logic             eff_global;
  attr_t            eff_attr;

  // a fill is dropped whenever an invalidate shares its cycle
  assign fill_go = fill_en && !inv_all && !inv_asid_en;
  assign tgt     = fill_use_idx ? fill_idx : rr_ptr;

  always_comb begin
    if (fill_basic) begin
      eff_size   = PG_4K;
      eff_global = 1'b0;
      eff_attr   = basic_attr();
    end else begin
      eff_size   = fill_size;
      eff_global = fill_global;
      eff_attr   = fill_attr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (fill_go && !fill_use_idx) begin
      if (rr_ptr == IDX_W'(ENTRIES - 1)) rr_ptr <= '0;
      else                               rr_ptr <= rr_ptr + IDX_W'(1);
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic wr_here;
    logic tag_kill;

    assign wr_here  = fill_go && (tgt == IDX_W'(i));
    assign tag_kill = inv_asid_en && !ent_global[i] && (ent_asid[i] == inv_asid);

    always_ff @(posedge clk) begin
      if (!rst_n)          ent_valid[i] <= 1'b0;
      else if (inv_all)    ent_valid[i] <= 1'b0;
      else if (tag_kill)   ent_valid[i] <= 1'b0;
      else if (wr_here)    ent_valid[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vpn[i]    <= '0;
        ent_pfn[i]    <= '0;
        ent_size[i]   <= '0;
        ent_asid[i]   <= '0;
        ent_global[i] <= 1'b0;
        ent_attr[i]   <= '0;
      end else if (wr_here) begin
        ent_vpn[i]    <= fill_vpn;
        ent_pfn[i]    <= fill_pfn;
        ent_size[i]   <= eff_size;
        ent_asid[i]   <= fill_asid;
        ent_global[i] <= eff_global;
        ent_attr[i]   <= eff_attr;
      end
    end
  end

endmodule

// File: rtl/vtlb_match.sv
module vtlb_match
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [VA_W-1:0]    va,
  input  logic [ASID_W-1:0]  ctx_asid,
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [VPN_W-1:0]   ent_vpn    [ENTRIES],
  input  logic [PFN_W-1:0]   ent_pfn    [ENTRIES],
  input  logic [1:0]         ent_size   [ENTRIES],
  input  logic [ASID_W-1:0]  ent_asid   [ENTRIES],
  input  logic               ent_global [ENTRIES],
  input  attr_t              ent_attr   [ENTRIES],
  output logic               hit,
  output logic               multi,
  output logic [PA_W-1:0]    pa,
  output attr_t              attr
);

  // widths that hold base + mask without wrapping
  localparam int XW  = VPN_W + PG_MAX_SHIFT + 1;
  localparam int PXW = PFN_W + PG_MAX_SHIFT + 1;

  logic [ENTRIES-1:0] hv;
  logic [PA_W-1:0]    pa_e [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [4:0]    sh;
    logic [XW-1:0] base, span, top, vax;
    logic          in_rng, tag_ok;
    logic [PXW-1:0] frame;

    always_comb begin
      sh     = page_shift(ent_size[i]);
      base   = XW'(ent_vpn[i]) << sh;
      span   = (XW'(1) << sh) - XW'(1);
      top    = base + span;
      vax    = XW'(va);
      in_rng = (vax >= base) && (vax <= top);
      tag_ok = ent_global[i] || (ent_asid[i] == ctx_asid);
      frame  = (PXW'(ent_pfn[i]) << sh) | PXW'(va & VA_W'(span));
    end

    assign hv[i]   = ent_valid[i] && in_rng && tag_ok;
    assign pa_e[i] = PA_W'(frame);
  end

  // lowest index wins; any second hit raises multi
  always_comb begin
    hit   = 1'b0;
    multi = 1'b0;
    pa    = '0;
    attr  = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (hv[k]) begin
        if (hit) begin
          multi = 1'b1;
        end else begin
          pa   = pa_e[k];
          attr = ent_attr[k];
        end
        hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vtlb_rsp_reg.sv
module vtlb_rsp_reg
  import vtlb_pkg::*;
#(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            in_hit,
  input  logic            in_multi,
  input  logic [PA_W-1:0] in_pa,
  input  attr_t           in_attr,
  input  logic            rsp_ready,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_multi,
  output logic [PA_W-1:0] rsp_pa,
  output attr_t           rsp_attr
);

  always_ff @(posedge clk) begin
    if (!rst_n)         rsp_valid <= 1'b0;
    else if (take)      rsp_valid <= 1'b1;
    else if (rsp_ready) rsp_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_pa    <= '0;
      rsp_attr  <= '0;
    end else if (take) begin
      rsp_hit   <= in_hit;
      rsp_multi <= in_multi;
      rsp_pa    <= in_pa;
      rsp_attr  <= in_attr;
    end
  end

endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VPN_W  = VA_W - PG_BASE_SHIFT,
  localparam int PFN_W  = PA_W - PG_BASE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] ctx_asid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_multi,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_mtype,
  output logic              rsp_nc,
  output logic              rsp_sect,
  output logic              rsp_xn,
  output logic [2:0]        rsp_ap,
  output logic [3:0]        rsp_dom,
  input  logic              fill_en,
  input  logic              fill_use_idx,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic              fill_basic,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [1:0]        fill_size,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  input  logic [1:0]        fill_mtype,
  input  logic              fill_nc,
  input  logic              fill_sect,
  input  logic              fill_xn,
  input  logic [2:0]        fill_ap,
  input  logic [3:0]        fill_dom,
  input  logic              inv_all,
  input  logic              inv_asid_en,
  input  logic [ASID_W-1:0] inv_asid
);

  logic [ENTRIES-1:0] ent_valid;
  logic [VPN_W-1:0]   ent_vpn    [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn    [ENTRIES];
  logic [1:0]         ent_size   [ENTRIES];
  logic [ASID_W-1:0]  ent_asid   [ENTRIES];
  logic               ent_global [ENTRIES];
  attr_t              ent_attr   [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;

  attr_t            fill_attr;
  logic             m_hit, m_multi;
  logic [PA_W-1:0]  m_pa;
  attr_t            m_attr;
  attr_t            r_attr;
  logic             take;

  assign fill_attr = '{mtype: fill_mtype, nc: fill_nc, sect: fill_sect,
                       xn: fill_xn, ap: fill_ap, dom: fill_dom};

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  vtlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
    .ASID_W(ASID_W), .IDX_W(IDX_W)
  ) u_store (
    .clk, .rst_n,
    .fill_en, .fill_use_idx, .fill_idx, .fill_basic,
    .fill_vpn, .fill_pfn, .fill_size, .fill_asid, .fill_global,
    .fill_attr,
    .inv_all, .inv_asid_en, .inv_asid,
    .ent_valid, .ent_vpn, .ent_pfn, .ent_size, .ent_asid,
    .ent_global, .ent_attr, .rr_ptr
  );

  vtlb_match #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W),
    .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
  ) u_match (
    .va(req_va), .ctx_asid,
    .ent_valid, .ent_vpn, .ent_pfn, .ent_size, .ent_asid,
    .ent_global, .ent_attr,
    .hit(m_hit), .multi(m_multi), .pa(m_pa), .attr(m_attr)
  );

  vtlb_rsp_reg #(.PA_W(PA_W)) u_rsp (
    .clk, .rst_n, .take,
    .in_hit(m_hit), .in_multi(m_multi), .in_pa(m_pa), .in_attr(m_attr),
    .rsp_ready, .rsp_valid, .rsp_hit, .rsp_multi, .rsp_pa,
    .rsp_attr(r_attr)
  );

  assign rsp_mtype = r_attr.mtype;
  assign rsp_nc    = r_attr.nc;
  assign rsp_sect  = r_attr.sect;
  assign rsp_xn    = r_attr.xn;
  assign rsp_ap    = r_attr.ap;
  assign rsp_dom   = r_attr.dom;

endmodule

// File: rtl/vtlb_chk.sv
module vtlb_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int PA_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_hit,
  input logic               rsp_multi,
  input logic [PA_W-1:0]    rsp_pa,
  input logic               fill_en,
  input logic               fill_use_idx,
  input logic               inv_all,
  input logic               inv_asid_en,
  input logic [ENTRIES-1:0] ent_valid,
  input logic [IDX_W-1:0]   rr_ptr
);

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_hit)
                                && $stable(rsp_multi));

  // R7
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R6
  multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_multi |-> rsp_hit);

  // R11
  inv_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> ent_valid == '0);

  // R12
  no_fill_on_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all || inv_asid_en |=> (ent_valid & ~$past(ent_valid)) == '0);

  // R12
  ptr_still_on_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all || inv_asid_en |=> $stable(rr_ptr));

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !fill_use_idx && !inv_all && !inv_asid_en |=>
      rr_ptr == (($past(rr_ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rr_ptr) + IDX_W'(1)));

  // R8
  ptr_hold_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && fill_use_idx |=> $stable(rr_ptr));

endmodule

bind vtlb_top vtlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .PA_W(PA_W)) u_chk (
  .clk, .rst_n, .req_valid, .req_ready, .rsp_valid, .rsp_ready,
  .rsp_hit, .rsp_multi, .rsp_pa, .fill_en, .fill_use_idx,
  .inv_all, .inv_asid_en, .ent_valid, .rr_ptr
);

// File: tb/vtlb_top_test.sv
`timescale 1ns/1ps
module vtlb_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_va = '0;
  logic [7:0]  ctx_asid = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic        rsp_hit, rsp_multi;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_mtype;
  logic        rsp_nc, rsp_sect, rsp_xn;
  logic [2:0]  rsp_ap;
  logic [3:0]  rsp_dom;
  logic        fill_en = 0, fill_use_idx = 0, fill_basic = 0, fill_global = 0;
  logic [3:0]  fill_idx = '0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [1:0]  fill_size = '0, fill_mtype = '0;
  logic [7:0]  fill_asid = '0, inv_asid = '0;
  logic        fill_nc = 0, fill_sect = 0, fill_xn = 0;
  logic [2:0]  fill_ap = '0;
  logic [3:0]  fill_dom = '0;
  logic        inv_all = 0, inv_asid_en = 0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic        hit;
    logic        multi;
    logic [31:0] pa;
    logic [11:0] attr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  vtlb_top uut (
    .clk, .rst_n, .req_valid, .req_ready, .req_va, .ctx_asid,
    .rsp_valid, .rsp_ready, .rsp_hit, .rsp_multi, .rsp_pa,
    .rsp_mtype, .rsp_nc, .rsp_sect, .rsp_xn, .rsp_ap, .rsp_dom,
    .fill_en, .fill_use_idx, .fill_idx, .fill_basic, .fill_vpn, .fill_pfn,
    .fill_size, .fill_asid, .fill_global, .fill_mtype, .fill_nc, .fill_sect,
    .fill_xn, .fill_ap, .fill_dom, .inv_all, .inv_asid_en, .inv_asid
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop one expectation per response handshake
  always @(negedge clk) begin
    #1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        check(0, "R7 unexpected response", 64'(rsp_pa), 64'd0);
      end else begin
        exp_t e;
        logic [11:0] a;
        e = sb.pop_front();
        a = {rsp_mtype, rsp_nc, rsp_sect, rsp_xn, rsp_ap, rsp_dom};
        check(rsp_hit == e.hit, {e.tag, " hit"}, 64'(rsp_hit), 64'(e.hit));
        check(rsp_multi == e.multi, {e.tag, " multi"}, 64'(rsp_multi), 64'(e.multi));
        check(rsp_pa == e.pa, {e.tag, " pa"}, 64'(rsp_pa), 64'(e.pa));
        check(a == e.attr, {e.tag, " attr"}, 64'(a), 64'(e.attr));
      end
    end
  end

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid,
                        input logic hit, input logic multi, input logic [31:0] pa,
                        input logic [11:0] attr, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = va;
    ctx_asid  = asid;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    e.hit = hit; e.multi = multi; e.pa = pa; e.attr = attr; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic fill(input bit use_idx, input logic [3:0] idx, input bit basic,
                      input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic [1:0] size, input logic [7:0] asid,
                      input bit glob, input logic [11:0] attr);
    @(negedge clk);
    fill_en = 1; fill_use_idx = use_idx; fill_idx = idx; fill_basic = basic;
    fill_vpn = vpn; fill_pfn = pfn; fill_size = size; fill_asid = asid;
    fill_global = glob;
    {fill_mtype, fill_nc, fill_sect, fill_xn, fill_ap, fill_dom} = attr;
    @(posedge clk);
    #1 fill_en = 0;
  endtask

  task automatic pulse_inv(input bit all, input bit by_tag, input logic [7:0] tag);
    @(negedge clk);
    inv_all = all; inv_asid_en = by_tag; inv_asid = tag;
    @(posedge clk);
    #1 begin inv_all = 0; inv_asid_en = 0; end
  endtask

  task automatic drain();
    int n = 0;
    while (sb.size() != 0 && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(sb.size() == 0, "R7 responses outstanding", 64'(sb.size()), 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'd1);
    lookup(32'h0000_0000, 8'd0, 0, 0, 32'h0, 12'h0, "R1 empty lookup");

    // slot 0: 4K, tag 5, normal xn ap=3 dom=2
    fill(0, 0, 0, 20'h12345, 20'hABCDE, 2'd0, 8'd5, 0, 12'h8B2);
    lookup(32'h1234_5678, 8'd5, 1, 0, 32'hABCD_E678, 12'h8B2, "R4 4K translate");
    lookup(32'h1234_5678, 8'd6, 0, 0, 32'h0, 12'h0, "R3 tag mismatch miss");
    lookup(32'h1234_5FFF, 8'd5, 1, 0, 32'hABCD_EFFF, 12'h8B2, "R2 upper edge");
    lookup(32'h1234_6000, 8'd5, 0, 0, 32'h0, 12'h0, "R2 above range");
    lookup(32'h1234_4FFF, 8'd5, 0, 0, 32'h0, 12'h0, "R2 below range");

    // slot 1: 64K global, tag 5, device
    fill(0, 0, 0, 20'h00003, 20'h00042, 2'd1, 8'd5, 1, 12'h4C5);
    lookup(32'h0003_ABCD, 8'd9, 1, 0, 32'h0042_ABCD, 12'h4C5, "R3 global any tag");
    // slot 2: 1M, tag 7, strongly ordered
    fill(0, 0, 0, 20'h00123, 20'h00800, 2'd2, 8'd7, 0, 12'h0F1);
    lookup(32'h123F_FFFF, 8'd7, 1, 0, 32'h800F_FFFF, 12'h0F1, "R2 1M edge");
    // slot 3: 16M, tag 2
    fill(0, 0, 0, 20'h00005, 20'h0000A, 2'd3, 8'd2, 0, 12'h9A7);
    lookup(32'h05AB_CDEF, 8'd2, 1, 0, 32'h0AAB_CDEF, 12'h9A7, "R5 16M attrs");
    lookup(32'h04FF_FFFF, 8'd2, 0, 0, 32'h0, 12'h0, "R2 16M below");

    // slot 10 explicit overlap with slot 0
    fill(1, 4'd10, 0, 20'h12345, 20'h11111, 2'd0, 8'd5, 0, 12'h123);
    lookup(32'h1234_5678, 8'd5, 1, 1, 32'hABCD_E678, 12'h8B2, "R6 lowest wins");
    // round-robin continues at slot 4
    fill(0, 0, 0, 20'h12345, 20'h22222, 2'd0, 8'd5, 0, 12'h456);
    // explicit overwrite of slot 0 moves it away
    fill(1, 4'd0, 0, 20'h00001, 20'h00002, 2'd0, 8'd5, 0, 12'h000);
    lookup(32'h1234_5678, 8'd5, 1, 1, 32'h2222_2678, 12'h456, "R8 rr slot 4 wins");
    lookup(32'h0000_1010, 8'd5, 1, 0, 32'h0000_2010, 12'h000, "R8 explicit slot 0");

    // basic fill with junk size/global/attrs
    fill(0, 0, 1, 20'h00777, 20'h00888, 2'd3, 8'd3, 1, 12'hFFF);
    lookup(32'h0077_7ABC, 8'd3, 1, 0, 32'h0088_8ABC, 12'h801, "R9 basic attrs");
    lookup(32'h0077_7ABC, 8'd4, 0, 0, 32'h0, 12'h0, "R9 basic non-global");
    lookup(32'h0077_8000, 8'd3, 0, 0, 32'h0, 12'h0, "R9 basic 4K size");

    // invalidate tag 5
    pulse_inv(0, 1, 8'd5);
    lookup(32'h1234_5678, 8'd5, 0, 0, 32'h0, 12'h0, "R10 tag 5 cleared");
    lookup(32'h0003_ABCD, 8'd5, 1, 0, 32'h0042_ABCD, 12'h4C5, "R10 global kept");
    lookup(32'h1230_0010, 8'd7, 1, 0, 32'h8000_0010, 12'h0F1, "R10 other tag kept");

    // invalidate-all together with a fill
    @(negedge clk);
    inv_all = 1; fill_en = 1; fill_use_idx = 0; fill_basic = 1;
    fill_vpn = 20'h0CCCC; fill_pfn = 20'h0DDDD; fill_asid = 8'd0;
    @(posedge clk);
    #1 begin inv_all = 0; fill_en = 0; fill_basic = 0; end
    lookup(32'h0CCC_C000, 8'd0, 0, 0, 32'h0, 12'h0, "R12 fill dropped");
    lookup(32'h0003_ABCD, 8'd5, 0, 0, 32'h0, 12'h0, "R11 global cleared");
    lookup(32'h05AB_CDEF, 8'd2, 0, 0, 32'h0, 12'h0, "R11 16M cleared");
    drain();

    // back-pressure
    fill(0, 0, 0, 20'h0AAAA, 20'h0BBBB, 2'd0, 8'd1, 0, 12'h321);
    @(negedge clk);
    rsp_ready = 1'b0;
    lookup(32'h0AAA_A123, 8'd1, 1, 0, 32'h0BBB_B123, 12'h321, "R7 first held");
    @(negedge clk);
    req_valid = 1'b1; req_va = 32'h0AAA_A456; ctx_asid = 8'd1;
    #1;
    check(req_ready == 1'b0, "R7 ready low while held", 64'(req_ready), 64'd0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      check(rsp_valid && rsp_pa == 32'h0BBB_B123, "R7 held stable",
            64'(rsp_pa), 64'h0BBB_B123);
    end
    @(negedge clk);
    rsp_ready = 1'b1;
    #1;
    check(req_ready == 1'b1, "R7 ready on release", 64'(req_ready), 64'd1);
    begin
      exp_t e;
      e.hit = 1; e.multi = 0; e.pa = 32'h0BBB_B456; e.attr = 12'h321;
      e.tag = "R7 second after release";
      sb.push_back(e);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule